// File: doc/BRIEF.md
# Hash-Verified Hybrid Address Generator

The block maps an N-bit key to a Q-bit address. It returns a nonzero address from 1 to k when the key is one of k registered keys, and it returns 0 for every other key. Most registered keys are resolved by a direct-mapped primary path. The key is split into P bound bits and R = N − P free bits. Each bound bit is XORed with one free bit, and the free bit for each position is fixed by a compile-time pairing. The P-bit result indexes a hash memory that returns a candidate address. The candidate then addresses a tag memory that holds the free bits of the registered key owning that address. The candidate is passed on only when the stored free bits equal the live free bits. The XOR pairing makes the bound bits recoverable from the hash and the free bits, so this comparison identifies the key uniquely.

When several registered keys land on the same hash column, the hash memory keeps the one with the smallest address. The others are placed in a small overflow table that compares full keys. The two paths can never both be nonzero for the same key, so the final address is their bitwise OR. Software or a loader fills all three stores through one shared write port. A lookup is presented with a valid strobe and its result is registered one cycle later.

Top module: `agen_hybrid`

## Requirements
- R1: Key bit i for i < P is bound bit i, and key bit P+j is free bit j. Hash bit i equals key[i] XOR key[P + PAIR_MAP[i]]. The default pairing is {2,1,0} for P = 3.
- R2: When the hash memory entry at the hash value is a nonzero address a, and the tag memory word at address a equals the key's free bits, the primary path yields a.
- R3: When the tag memory word at the candidate address differs from the key's free bits, the primary path yields 0.
- R4: A hash memory entry of 0 yields 0 on the primary path, even when tag memory word 0 equals the key's free bits.
- R5: An overflow slot whose stored address is nonzero and whose stored key equals the live key yields that address. A slot that stores address 0 never matches.
- R6: The result is the bitwise OR of the primary and overflow paths. With consistent contents, the two paths are never nonzero together.
- R7: A lookup presented with key_vld_i high in one cycle appears on addr_o, with addr_vld_o high, after the next rising clock edge. addr_vld_o is low after any edge at which key_vld_i was low.
- R8: addr_o holds its last value through cycles without a lookup.
- R9: During reset, and until the first lookup after it, addr_o and addr_vld_o are 0.
- R10: The write select encoding is 0 for the hash memory, 1 for the tag memory and 2 for an overflow slot. Select 3 changes no store.
- R11: A write is visible to a lookup presented in the next cycle. The write data layout is as follows. The hash memory takes wr_data_i[Q-1:0]. The tag memory takes wr_data_i[R-1:0]. An overflow slot takes the key in wr_data_i[N-1:0] and the address in wr_data_i[N+Q-1:N].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Write strobe for the selected store |
| wr_sel_i | input | 2 | Store select: 0 hash, 1 tag, 2 overflow, 3 none |
| wr_addr_i | input | WA_W | Entry or slot number |
| wr_data_i | input | N+Q | Write data (layout per R11) |
| key_vld_i | input | 1 | Lookup strobe |
| key_i | input | N | Key to look up |
| addr_vld_o | output | 1 | Result valid, one cycle after the strobe |
| addr_o | output | Q | Registered address, 0 when the key is not registered |

## Verification
Several properties are checked on every cycle. The valid output must follow the lookup strobe by one cycle, and the address must hold between lookups. Whenever a lookup is active, the primary and overflow paths must never both report a hit, and at most one overflow slot may hit. Other behaviour can only be shown by the bench's scenarios:
- correct addresses across the whole key space for a loaded list, including the collided key served by the overflow table;
- zeroing on a tag mismatch;
- zeroing on an empty hash entry;
- the ignored write select.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    WSEL_HASH = 2'd0,
    WSEL_TAG  = 2'd1,
    WSEL_OVF  = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/agen_hash.sv
module agen_hash #(
  parameter int N_BITS = 6,
  parameter int P_BITS = 3,
  parameter int PAIR_MAP [P_BITS] = '{2, 1, 0}
) (
  input  logic [N_BITS-1:0] key_i,
  output logic [P_BITS-1:0] hash_o
);
  // R1: each bound bit folded with its paired free bit
  for (genvar gi = 0; gi < P_BITS; gi++) begin : g_fold
    assign hash_o[gi] = key_i[gi] ^ key_i[P_BITS + PAIR_MAP[gi]];
  end
endmodule

// File: rtl/agen_prim.sv
module agen_prim #(
  parameter int P_BITS = 3,
  parameter int Q_BITS = 3,
  parameter int R_BITS = 3
) (
  input  logic              clk,
  input  logic              hash_we_i,
  input  logic [P_BITS-1:0] hash_waddr_i,
  input  logic [Q_BITS-1:0] hash_wdata_i,
  input  logic              tag_we_i,
  input  logic [Q_BITS-1:0] tag_waddr_i,
  input  logic [R_BITS-1:0] tag_wdata_i,
  input  logic [P_BITS-1:0] hash_i,
  input  logic [R_BITS-1:0] free_i,
  output logic [Q_BITS-1:0] idx_o
);
  localparam int HDEPTH = 1 << P_BITS;
  localparam int TDEPTH = 1 << Q_BITS;

  logic [Q_BITS-1:0] hash_mem [HDEPTH];
  logic [R_BITS-1:0] tag_mem  [TDEPTH];
  logic [Q_BITS-1:0] cand;
  logic [R_BITS-1:0] tag_rd;
  logic              tag_eq;

  always_ff @(posedge clk) begin
    if (hash_we_i) hash_mem[hash_waddr_i] <= hash_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (tag_we_i) tag_mem[tag_waddr_i] <= tag_wdata_i;
  end

  always_comb begin
    cand   = hash_mem[hash_i];
    tag_rd = tag_mem[cand];
    tag_eq = (tag_rd == free_i);
    // R2 R3 R4: pass candidate only on nonzero entry and matching tag
    idx_o  = (tag_eq && (cand != '0)) ? cand : '0;
  end
endmodule

// File: rtl/agen_ovf.sv
module agen_ovf #(
  parameter int N_BITS = 6,
  parameter int Q_BITS = 3,
  parameter int SLOTS  = 4,
  parameter int SA_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SA_W-1:0]   waddr_i,
  input  logic [N_BITS-1:0] wkey_i,
  input  logic [Q_BITS-1:0] widx_i,
  input  logic              look_i,
  input  logic [N_BITS-1:0] key_i,
  output logic [Q_BITS-1:0] idx_o
);
  logic [N_BITS-1:0] slot_key [SLOTS];
  logic [Q_BITS-1:0] slot_idx [SLOTS];
  logic [SLOTS-1:0]  hit;
  logic [Q_BITS-1:0] part [SLOTS+1];

  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
    logic wsel;
    assign wsel = we_i && (waddr_i == SA_W'(gs));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_idx[gs] <= '0;
      end else if (wsel) begin
        slot_idx[gs] <= widx_i;
      end
    end

    always_ff @(posedge clk) begin
      if (wsel) slot_key[gs] <= wkey_i;
    end

    // R5: empty slot (address 0) never matches
    assign hit[gs]    = (slot_idx[gs] != '0) && (slot_key[gs] == key_i);
    assign part[gs+1] = part[gs] | (hit[gs] ? slot_idx[gs] : '0);
  end

  assign part[0] = '0;
  assign idx_o   = part[SLOTS];

  // R5
  ovf_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_i |-> $onehot0(hit));
endmodule

// File: rtl/agen_hybrid.sv
module agen_hybrid #(
  parameter int N_BITS = 6,
  parameter int P_BITS = 3,
  parameter int Q_BITS = 3,
  parameter int SLOTS  = 4,
  parameter int PAIR_MAP [P_BITS] = '{2, 1, 0},
  parameter int R_BITS = N_BITS - P_BITS,
  parameter int SA_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  parameter int WA_W   = (P_BITS > Q_BITS) ? ((P_BITS > SA_W) ? P_BITS : SA_W)
                                           : ((Q_BITS > SA_W) ? Q_BITS : SA_W),
  parameter int WD_W   = N_BITS + Q_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [WD_W-1:0]   wr_data_i,
  input  logic              key_vld_i,
  input  logic [N_BITS-1:0] key_i,
  output logic              addr_vld_o,
  output logic [Q_BITS-1:0] addr_o
);
  import agen_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_ni;
  wsel_e             wsel;
  logic              hash_we, tag_we, ovf_we;
  logic [P_BITS-1:0] hash_val;
  logic [Q_BITS-1:0] prim_idx, ovf_idx;
  logic              vld_d, vld_q;
  logic [Q_BITS-1:0] addr_d, addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // R10: decode of the shared write port
  always_comb begin
    wsel    = wsel_e'(wr_sel_i);
    hash_we = wr_en_i && (wsel == WSEL_HASH);
    tag_we  = wr_en_i && (wsel == WSEL_TAG);
    ovf_we  = wr_en_i && (wsel == WSEL_OVF);
  end

  agen_hash #(
    .N_BITS(N_BITS), .P_BITS(P_BITS), .PAIR_MAP(PAIR_MAP)
  ) u_hash (
    .key_i (key_i),
    .hash_o(hash_val)
  );

  agen_prim #(
    .P_BITS(P_BITS), .Q_BITS(Q_BITS), .R_BITS(R_BITS)
  ) u_prim (
    .clk         (clk),
    .hash_we_i   (hash_we),
    .hash_waddr_i(wr_addr_i[P_BITS-1:0]),
    .hash_wdata_i(wr_data_i[Q_BITS-1:0]),
    .tag_we_i    (tag_we),
    .tag_waddr_i (wr_addr_i[Q_BITS-1:0]),
    .tag_wdata_i (wr_data_i[R_BITS-1:0]),
    .hash_i      (hash_val),
    .free_i      (key_i[N_BITS-1:P_BITS]),
    .idx_o       (prim_idx)
  );

  agen_ovf #(
    .N_BITS(N_BITS), .Q_BITS(Q_BITS), .SLOTS(SLOTS), .SA_W(SA_W)
  ) u_ovf (
    .clk    (clk),
    .rst_n  (rst_ni),
    .we_i   (ovf_we),
    .waddr_i(wr_addr_i[SA_W-1:0]),
    .wkey_i (wr_data_i[N_BITS-1:0]),
    .widx_i (wr_data_i[N_BITS+Q_BITS-1:N_BITS]),
    .look_i (key_vld_i),
    .key_i  (key_i),
    .idx_o  (ovf_idx)
  );

  // R6 R7 R8: merge and next state
  always_comb begin
    vld_d  = key_vld_i;
    addr_d = key_vld_i ? (prim_idx | ovf_idx) : addr_q;
  end

  // R9: reset state
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign addr_vld_o = vld_q;
  assign addr_o     = addr_q;

  // R6
  paths_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (key_vld_i && (prim_idx != '0)) |-> (ovf_idx == '0));

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(key_vld_i) |-> addr_vld_o);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(key_vld_i) |-> !addr_vld_o);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_vld_o |-> $stable(addr_o));
endmodule

// File: tb/agen_hybrid_tb.sv
module agen_hybrid_tb;
  localparam int N = 6, P = 3, Q = 3, R = 3, S = 4, WA = 3, WD = 9, K = 7;
  localparam int PM [P] = '{2, 1, 0};
  // registered keys, address = position + 1; key bit i = x(i+1)
  localparam logic [N-1:0] REG_VEC [K] = '{
    6'b010000, 6'b010010, 6'b010100, 6'b011100,
    6'b100000, 6'b110111, 6'b111010
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [WA-1:0] wr_addr_i = '0;
  logic [WD-1:0] wr_data_i = '0;
  logic key_vld_i = 1'b0;
  logic [N-1:0] key_i = '0;
  logic addr_vld_o;
  logic [Q-1:0] addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [Q-1:0] hexp [1 << P];
  logic [R-1:0] texp [1 << Q];

  always #4 clk = ~clk;

  agen_hybrid #(.N_BITS(N), .P_BITS(P), .Q_BITS(Q), .SLOTS(S), .PAIR_MAP(PM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .key_vld_i(key_vld_i),
    .key_i(key_i), .addr_vld_o(addr_vld_o), .addr_o(addr_o)
  );

  function automatic logic [P-1:0] fold(logic [N-1:0] k);
    logic [P-1:0] y;
    for (int i = 0; i < P; i++) y[i] = k[i] ^ k[P + PM[i]];
    return y;
  endfunction

  function automatic logic [Q-1:0] ref_addr(logic [N-1:0] k);
    for (int i = 0; i < K; i++) if (REG_VEC[i] == k) return Q'(i + 1);
    return '0;
  endfunction

  task automatic check(string req, logic [Q-1:0] act, logic [Q-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [WA-1:0] a, logic [WD-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic look(logic [N-1:0] k);
    @(negedge clk);
    key_vld_i = 1'b1; key_i = k;
    @(negedge clk);
    key_vld_i = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nov;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 addr", addr_o, '0);
    check("R9 vld", Q'(addr_vld_o), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 after release", addr_o, '0);

    // build contents: smallest address keeps a column, rest overflow
    for (int i = 0; i < (1 << P); i++) hexp[i] = '0;
    for (int i = 0; i < (1 << Q); i++) texp[i] = '0;
    nov = 0;
    for (int i = 0; i < K; i++) begin
      logic [P-1:0] y;
      y = fold(REG_VEC[i]);
      if (hexp[y] == '0) begin
        hexp[y] = Q'(i + 1);
        texp[i + 1] = REG_VEC[i][N-1:P];
      end else begin
        wr(2'd2, WA'(nov), {Q'(i + 1), REG_VEC[i]});
        nov++;
      end
    end
    for (int s = nov; s < S; s++) wr(2'd2, WA'(s), '0);
    for (int i = 0; i < (1 << P); i++) wr(2'd0, WA'(i), WD'(hexp[i]));
    for (int i = 0; i < (1 << Q); i++) wr(2'd1, WA'(i), WD'(texp[i]));

    // R1 R2 R3 R5 R6: whole key space against reference lookup
    for (int k = 0; k < (1 << N); k++) begin
      look(N'(k));
      check("R1 R2 R6 sweep", addr_o, ref_addr(N'(k)));
      check("R7 valid", Q'(addr_vld_o), Q'(1));
    end

    // R7 valid drops, R8 hold
    look(REG_VEC[5]);
    @(negedge clk);
    check("R7 drop", Q'(addr_vld_o), '0);
    check("R8 hold", addr_o, Q'(6));

    // R5: collided key served by overflow slot
    look(REG_VEC[3]);
    check("R5 overflow", addr_o, Q'(4));

    // R3: corrupt tag of address 2
    wr(2'd1, WA'(2), WD'(~REG_VEC[1][N-1:P]));
    look(REG_VEC[1]);
    check("R3 mismatch", addr_o, '0);
    wr(2'd1, WA'(2), WD'(REG_VEC[1][N-1:P]));
    look(REG_VEC[1]);
    check("R11 restore", addr_o, Q'(2));

    // R4: empty hash entry with tag word 0 matching
    wr(2'd1, WA'(0), WD'(REG_VEC[4][N-1:P]));
    wr(2'd0, WA'(fold(REG_VEC[4])), '0);
    look(REG_VEC[4]);
    check("R4 zero entry", addr_o, '0);
    wr(2'd0, WA'(fold(REG_VEC[4])), WD'(5));
    look(REG_VEC[4]);
    check("R11 rewrite", addr_o, Q'(5));

    // R10: select 3 writes nothing
    wr(2'd3, WA'(fold(REG_VEC[6])), '1);
    wr(2'd3, WA'(0), '1);
    look(REG_VEC[6]);
    check("R10 ignored sel", addr_o, Q'(7));
    look(REG_VEC[0]);
    check("R10 ignored sel b", addr_o, Q'(1));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule